// File: doc/BRIEF.md
# Lane-Split Vector Shuffle Unit

This block is a 256-bit shuffle datapath. It builds every destination element from an index that picks one element out of two source vectors, called J and K. In the main shuffle mode the vector is cut into two 128-bit lanes that work independently. Each lane draws only from its own half of J and its own half of K. Elements may be 8, 16, 32 or 64 bits wide. A second mode permutes 32-bit words of J across the whole vector, with no lane boundary.

The caller chooses the index source before it reaches the block. For byte shuffles the index is a separate operand. For the wider sizes it is the old destination contents. Either way it enters on `idxVec`. Every result element depends only on the operands sampled in that cycle. The result is registered and appears one clock after the request.

Top module: `vshuf_unit`

## Requirements
- R1: A synchronous active-high `rst` drives `outValid` low on the clock edge where it is sampled high.
- R2: A request sampled with `inValid` high produces `outValid` high on the next clock edge, together with its result. A cycle with `inValid` low produces `outValid` low on the next edge.
- R3: `result` keeps its last value through every cycle in which no request is sampled.
- R4: In shuffle mode, call the element count of the whole vector n. Then n = 32, 16, 8 or 4 for byte, halfword, word and doubleword. Element i of `idxVec`, taken at the same width, supplies k = (its low 8 bits) mod n. No other index bit has an effect.
- R5: In shuffle mode, with m = n/2, a destination element i < m (lower lane) takes K element k when k < m. Otherwise it takes J element k−m.
- R6: In shuffle mode, a destination element i ≥ m (upper lane) takes K element k+m when k < m. Otherwise it takes J element k.
- R7: With `opSel` = 0, `elemSize` selects the element width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. Element i occupies bits [i*W +: W] of every vector.
- R8: With `opSel` = 1, result word w (bits [w*32 +: 32]) is J word (bits [2:0] of `idxVec` word w). Selection crosses lanes freely, and `srcK` and `elemSize` have no effect.
- R9: Each destination element is chosen independently, so one source element may appear in several destination positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe; operands are sampled when it is high |
| opSel | input | 1 | 0 = lane-split shuffle, 1 = cross-lane word permute |
| elemSize | input | 2 | Element width for shuffle mode |
| srcJ | input | 256 | First source vector (J) |
| srcK | input | 256 | Second source vector (K) |
| idxVec | input | 256 | Index vector |
| outValid | output | 1 | Result valid, one clock after the request |
| result | output | 256 | Registered shuffle result |

## Verification
The hardest case to reach is an upper-lane element whose index wraps. Such an index has bits set above the modulo range, and it must still stay within the upper halves of J and K. Random full-byte index patterns do not reliably aim at one particular lane element. So the stimulus mixes unrestricted random bytes with directed vectors for each element size. These vectors fill the upper-lane indices with values such as 0xFF and m, and repeat a single index across all positions to force duplicate picks. Idle gaps and a mid-run reset are interleaved, so that result holding and valid clearing are compared cycle by cycle against the behavioural model.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } elem_size_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic       capture;
    logic       permMode;
    elem_size_e size;
  } shuf_strobe_t;
endpackage

// File: rtl/vshuf_ctrl.sv
module vshuf_ctrl
  import vshuf_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         opSel,
  input  logic [1:0]   elemSize,
  output shuf_strobe_t strobe,
  output logic         outValid
);
  logic validQ;

  always_comb begin
    strobe.capture  = inValid && !rst;
    strobe.permMode = opSel;
    strobe.size     = elem_size_e'(elemSize);
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  assign outValid = validQ;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !outValid); // R1
endmodule

// File: rtl/vshuf_datapath.sv
module vshuf_datapath
  import vshuf_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  shuf_strobe_t     strobe,
  input  logic [VEC_W-1:0] srcJ,
  input  logic [VEC_W-1:0] srcK,
  input  logic [VEC_W-1:0] idxVec,
  output logic [VEC_W-1:0] result
);
  localparam int NUM_SIZES = 4;
  localparam int NW        = VEC_W / WORD_W;
  localparam int WSEL      = $clog2(NW);

  logic [NUM_SIZES-1:0][VEC_W-1:0] cand;
  logic [VEC_W-1:0] permRes;
  logic [VEC_W-1:0] nextRes;
  logic [VEC_W-1:0] resultQ;

  // Lane-split shuffle, one candidate per element size
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int W  = 8 << s;
    localparam int N  = VEC_W / W;
    localparam int IB = $clog2(N);
    for (genvar i = 0; i < N; i++) begin : g_elem
      localparam bit UPPER = (i >= N / 2);
      logic [IB-1:0] k;
      logic [IB-1:0] pos;
      // modulo n keeps only the low IB bits
      assign k   = idxVec[i*W +: IB];
      // the lane comes from the destination, the offset from the index
      assign pos = {UPPER, k[IB-2:0]};
      assign cand[s][i*W +: W] = k[IB-1] ? srcJ[pos*W +: W] : srcK[pos*W +: W];
    end
  end

  // Cross-lane word permute from J
  for (genvar w = 0; w < NW; w++) begin : g_perm
    logic [WSEL-1:0] sel;
    assign sel = idxVec[w*WORD_W +: WSEL];
    assign permRes[w*WORD_W +: WORD_W] = srcJ[sel*WORD_W +: WORD_W];
  end

  assign nextRes = strobe.permMode ? permRes : cand[strobe.size];

  always_ff @(posedge clk) begin
    if (strobe.capture) resultQ <= nextRes;
  end

  assign result = resultQ;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(resultQ)); // R3
endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit
  import vshuf_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             opSel,
  input  logic [1:0]       elemSize,
  input  logic [VEC_W-1:0] srcJ,
  input  logic [VEC_W-1:0] srcK,
  input  logic [VEC_W-1:0] idxVec,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  localparam int LANE_W = VEC_W / 2;

  shuf_strobe_t strobe;

  vshuf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .elemSize(elemSize), .strobe(strobe), .outValid(outValid)
  );

  vshuf_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .srcJ(srcJ), .srcK(srcK),
    .idxVec(idxVec), .result(result)
  );

  logic [VEC_W-1:0] permProbe;
  assign permProbe = srcJ >> {idxVec[2:0], 5'b0};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> outValid == $past(inValid)); // R2
  AST_PERM_WORD0: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel) |=> result[31:0] == $past(permProbe[31:0])); // R8
  AST_BYTE_LOW_LANE: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel && elemSize == 2'b00 && idxVec[4:0] == 5'd0)
    |=> result[7:0] == $past(srcK[7:0])); // R5
  AST_DWORD_UP_LANE: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel && elemSize == 2'b11 && idxVec[LANE_W +: 2] == 2'b10)
    |=> result[LANE_W +: 64] == $past(srcJ[LANE_W +: 64])); // R6
endmodule

// File: tb/vshuf_unit_test.sv
module vshuf_unit_test;
  localparam int CLK_P = 10;
  localparam int VW = 256;

  logic clk = 1'b0;
  logic rst, inValid, opSel;
  logic [1:0] elemSize;
  logic [VW-1:0] srcJ, srcK, idxVec;
  logic outValid;
  logic [VW-1:0] result;

  int compared = 0;
  int mismatched = 0;
  logic expValid;
  logic expKnown;
  logic [VW-1:0] expRes;

  vshuf_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .elemSize(elemSize),
    .srcJ(srcJ), .srcK(srcK), .idxVec(idxVec), .outValid(outValid), .result(result)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [VW-1:0] rand256();
    logic [VW-1:0] v;
    for (int q = 0; q < VW/32; q++) v[q*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural reference built from the requirements
  function automatic logic [VW-1:0] refModel(logic op, logic [1:0] sz,
      logic [VW-1:0] j, logic [VW-1:0] k, logic [VW-1:0] idx);
    logic [VW-1:0] r;
    int w, n, m, kk, e;
    logic fromJ;
    r = '0;
    if (op) begin
      for (int i = 0; i < 8; i++) begin
        kk = idx[i*32 +: 8] % 8;
        for (int b = 0; b < 32; b++) r[i*32+b] = j[kk*32+b];
      end
    end else begin
      w = 8 << sz;
      n = VW / w;
      m = n / 2;
      for (int i = 0; i < n; i++) begin
        kk = 0;
        for (int b = 0; b < 8; b++) kk += int'(idx[i*w+b]) << b;
        kk = kk % n;
        if (i < m) begin
          fromJ = (kk >= m); e = fromJ ? kk - m : kk;
        end else begin
          fromJ = (kk >= m); e = fromJ ? kk : kk + m;
        end
        for (int b = 0; b < w; b++) r[i*w+b] = fromJ ? j[e*w+b] : k[e*w+b];
      end
    end
    return r;
  endfunction

  task automatic cyc(input logic r, input logic v, input logic op, input logic [1:0] sz,
                     input logic [VW-1:0] j, input logic [VW-1:0] k,
                     input logic [VW-1:0] idx, input string tag);
    rst = r; inValid = v; opSel = op; elemSize = sz; srcJ = j; srcK = k; idxVec = idx;
    @(posedge clk);
    if (r) expValid = 1'b0;
    else begin
      expValid = v;
      if (v) begin expRes = refModel(op, sz, j, k, idx); expKnown = 1'b1; end
    end
    @(negedge clk);
    compared++;
    if (outValid !== expValid) begin
      mismatched++;
      $display("FAIL %s outValid actual=%b expected=%b", tag, outValid, expValid);
    end else if (expKnown && result !== expRes) begin
      mismatched++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, expRes);
    end
  endtask

  function automatic logic [VW-1:0] fillIdx(logic [1:0] sz, logic [7:0] lowVal, logic [7:0] upVal);
    logic [VW-1:0] v;
    int w, n;
    v = '0;
    w = 8 << sz; n = VW / w;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) v[i*w+b] = (i < n/2) ? lowVal[b] : upVal[b];
    return v;
  endfunction

  initial begin
    #(CLK_P*200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [VW-1:0] j, k;
    logic [1:0] sz;
    int m;
    expValid = 1'b0; expKnown = 1'b0; expRes = '0;
    rst = 1'b1; inValid = 1'b0; opSel = 1'b0; elemSize = 2'b00;
    srcJ = '0; srcK = '0; idxVec = '0;
    @(negedge clk);
    // R1: reset state
    cyc(1, 1, 0, 2'b00, '0, '0, '0, "R1");
    cyc(1, 0, 0, 2'b00, '0, '0, '0, "R1");

    // R5 R6 R7: directed lane cases for each size, including wrap (0xFF) and k = m
    for (int s = 0; s < 4; s++) begin
      sz = 2'(s);
      m = (VW / (8 << s)) / 2;
      j = rand256(); k = rand256();
      cyc(0, 1, 0, sz, j, k, fillIdx(sz, 8'h00, 8'h00), "R5");
      cyc(0, 1, 0, sz, j, k, fillIdx(sz, 8'(m), 8'(m)), "R6");
      cyc(0, 1, 0, sz, j, k, fillIdx(sz, 8'hFF, 8'hFF), "R4");
      cyc(0, 1, 0, sz, j, k, fillIdx(sz, 8'(m-1), 8'(2*m-1)), "R6");
      // R9: the same index everywhere yields duplicates
      cyc(0, 1, 0, sz, j, k, fillIdx(sz, 8'd1, 8'd1), "R9");
      // R4: bits above the low byte of a wide element are ignored
      cyc(0, 1, 0, sz, j, k, ~fillIdx(sz, 8'hFF, 8'hFF) | fillIdx(sz, 8'd3, 8'd3), "R4");
      // R3: idle cycles hold the result
      cyc(0, 0, 0, sz, rand256(), rand256(), rand256(), "R3");
      cyc(0, 0, 1, sz, rand256(), rand256(), rand256(), "R3");
    end

    // R8: word permute crossing lanes, K and size ignored
    j = rand256();
    cyc(0, 1, 1, 2'b00, j, rand256(), fillIdx(2'b10, 8'd7, 8'd0), "R8");
    cyc(0, 1, 1, 2'b11, j, rand256(), fillIdx(2'b10, 8'hFC, 8'h05), "R8");

    // R1: mid-run reset, then R2 latency
    cyc(1, 1, 0, 2'b01, rand256(), rand256(), rand256(), "R1");
    cyc(0, 1, 0, 2'b01, rand256(), rand256(), rand256(), "R2");

    // Random mix
    for (int t = 0; t < 600; t++) begin
      logic v, op;
      string tag;
      v = ($urandom % 4) != 0;
      op = ($urandom % 4) == 0;
      sz = 2'($urandom);
      tag = !v ? "R3" : op ? "R8" : (sz == 2'b00) ? "R5" : (sz[0] ? "R6" : "R7");
      cyc(0, v, op, sz, rand256(), rand256(), rand256(), tag);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule